// File: doc/BRIEF.md
# Glitch-Filtered Input Capture

This block takes an asynchronous event line, cleans it up and records when it changed. The line first crosses into the system clock domain through a short flip-flop chain. An optional majority-free glitch filter then follows, which accepts a new level only when four back-to-back synchronized samples agree. A selectable rising or falling edge on the resulting level copies a free-running 16-bit count into a capture register and raises a one-cycle valid strobe.

The filter runs on the system clock only, so its timing does not depend on how the count itself is prescaled. The filter is a two-state machine. The state `FLT_LOW` moves to `FLT_HIGH` on the transition RISE, taken when the sample window is all ones. The state `FLT_HIGH` moves to `FLT_LOW` on the transition FALL, taken when the window is all zeros. In every other case the machine stays in its current state. The edge stage compares the chosen level against its value one clock earlier.

Top module: `nf_capture`

## Requirements
- R1: During and right after reset, `cap_val` is 0, `cap_vld` is 0 and the filter state is `FLT_LOW`, so no edge is reported when the line idles low.
- R2: With `flt_en`=0, when `evt_in` changes before rising clock edge k, the capture happens at edge k+2 and loads the `cnt_in` value present at that edge.
- R3: With `flt_en`=1, the filtered level changes only when the four most recent synchronized samples are equal. A pulse on `evt_in` shorter than four clock cycles produces no capture.
- R4: With `flt_en`=1, a change that survives the filter is captured at edge k+6, which is exactly four clocks later than in R2.
- R5: `edge_sel`=0 captures on a low-to-high change of the selected level. `edge_sel`=1 captures on a high-to-low change. A change in the other direction causes no capture.
- R6: On a capture, `cap_val` takes the `cnt_in` value sampled at that clock edge, and `cap_vld` is high for exactly that one cycle.
- R7: Between captures, `cap_val` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_en | input | 1 | 1 routes the level through the four-sample filter |
| evt_in | input | 1 | Raw asynchronous event line |
| edge_sel | input | 1 | 0 = rising edge, 1 = falling edge |
| cnt_in | input | 16 | Count value to be captured |
| cap_val | output | 16 | Last captured count |
| cap_vld | output | 1 | One-cycle strobe on each capture |

## Verification
The filter-window properties assume that the sample history starts out clean after reset. They also assume that `flt_en` and `edge_sel` change only while the line has been low and stable long enough for both paths to agree. The stimulus therefore changes those controls only after long idle gaps at level 0. For each setting of those controls, it sends a single pulse of one to six cycles. The expected captured value is computed from the pulse start count, the fixed path delay and the pulse width. A pulse that should be rejected is confirmed by the absence of a strobe and an unchanged capture register.

// File: rtl/nf_pkg.sv
package nf_pkg;
    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_t;
endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= 1'b0;
                end else begin
                    if (s == 0) chain_q[s] <= d_in;
                    else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/nf_filter.sv
module nf_filter
    import nf_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_in,
    output logic lvl_out
);
    localparam int HIST_W = WIN - 1;

    logic [HIST_W-1:0] hist_q;
    logic [WIN-1:0]    window;
    logic              all_one;
    logic              all_zero;
    flt_state_t        state_q;
    flt_state_t        state_d;

    assign window   = {hist_q, smp_in};
    assign all_one  = &window;
    assign all_zero = ~|window;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= window[HIST_W-1:0];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LOW:  if (all_one)  state_d = FLT_HIGH;  // RISE
            FLT_HIGH: if (all_zero) state_d = FLT_LOW;   // FALL
            default:  state_d = FLT_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLT_HIGH: lvl_out = 1'b1;
            default:  lvl_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/nf_edge_cap.sv
module nf_edge_cap
    import nf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_in,
    input  logic             edge_sel,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_vld
);
    logic       lvl_prev_q;
    logic       hit;
    edge_kind_t kind;

    assign kind = edge_kind_t'(edge_sel);

    always_comb begin
        unique case (kind)
            EDGE_RISE: hit =  lvl_in && !lvl_prev_q;
            EDGE_FALL: hit = !lvl_in &&  lvl_prev_q;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= 1'b0;
            cap_val    <= '0;
            cap_vld    <= 1'b0;
        end else begin
            lvl_prev_q <= lvl_in;
            cap_vld    <= hit;
            if (hit) cap_val <= cnt_in;
        end
    end
endmodule

// File: rtl/nf_capture.sv
module nf_capture
    import nf_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_en,
    input  logic             evt_in,
    input  logic             edge_sel,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_vld
);
    logic sync_lvl;
    logic flt_lvl;
    logic sel_lvl;

    nf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (evt_in),
        .d_out (sync_lvl)
    );

    nf_filter #(.WIN(WIN)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_in  (sync_lvl),
        .lvl_out (flt_lvl)
    );

    assign sel_lvl = flt_en ? flt_lvl : sync_lvl;

    nf_edge_cap #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (sel_lvl),
        .edge_sel (edge_sel),
        .cnt_in   (cnt_in),
        .cap_val  (cap_val),
        .cap_vld  (cap_vld)
    );
endmodule

// File: rtl/nf_capture_chk.sv
module nf_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_in,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_vld,
    input logic             sync_lvl,
    input logic             flt_lvl
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAN: assert (cap_vld == 1'b0 && flt_lvl == 1'b0); // R1
        end
    end

    AST_FLT_RISE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_lvl) |-> ($past(sync_lvl, 1) && $past(sync_lvl, 2) &&
                            $past(sync_lvl, 3) && $past(sync_lvl, 4))); // R3

    AST_FLT_FALL_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_lvl) |-> (!$past(sync_lvl, 1) && !$past(sync_lvl, 2) &&
                            !$past(sync_lvl, 3) && !$past(sync_lvl, 4))); // R3

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |=> !cap_vld); // R6

    AST_CAP_LOADS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_vld) |-> (cap_val == $past(cnt_in))); // R6

    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_vld && $past(rst_n)) |-> $stable(cap_val)); // R7
endmodule

bind nf_capture nf_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_in   (cnt_in),
    .cap_val  (cap_val),
    .cap_vld  (cap_vld),
    .sync_lvl (sync_lvl),
    .flt_lvl  (flt_lvl)
);

// File: tb/nf_capture_tb.sv
module nf_capture_tb_top;
    localparam int CLK_P = 10;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flt_en = 1'b0;
    logic          evt_in = 1'b0;
    logic          edge_sel = 1'b0;
    logic [CW-1:0] cnt_r = '0;
    logic [CW-1:0] cap_val;
    logic          cap_vld;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cnt_r <= cnt_r + 1'b1;

    nf_capture dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_en   (flt_en),
        .evt_in   (evt_in),
        .edge_sel (edge_sel),
        .cnt_in   (cnt_r),
        .cap_val  (cap_val),
        .cap_vld  (cap_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One pulse of width w cycles; counts strobes and records the captured value.
    task automatic pulse_run(input int en, input int sel, input int w);
        int c0;
        int hits;
        int got;
        int prev;
        int exp_hits;
        int exp_val;
        string tag;
        hits = 0;
        got  = 0;
        prev = int'(cap_val);
        c0   = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (cap_vld) begin
                hits++;
                got = int'(cap_val);
            end
            if (i == 0) c0 = int'(cnt_r);
            evt_in = (i < w);
        end
        exp_hits = (en == 0 || w >= 4) ? 1 : 0;
        exp_val  = (c0 + (en != 0 ? 6 : 2) + (sel != 0 ? w : 0)) & 16'hFFFF;
        tag = (en != 0) ? ((w >= 4) ? "R4" : "R3") : "R2";
        check(tag, hits, exp_hits);
        if (exp_hits == 1) begin
            check(sel != 0 ? "R5 fall" : "R5 rise", got, exp_val);
        end else begin
            check("R7 hold", int'(cap_val), prev);
        end
        idle(10);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        check("R1 cap_val", int'(cap_val), 0);
        check("R1 cap_vld", int'(cap_vld), 0);
        rst_n = 1'b1;
        idle(12);
        check("R1 no spurious", int'(cap_vld), 0);
        check("R1 cap idle", int'(cap_val), 0);
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < 2; sel++) begin
                @(negedge clk);
                flt_en   = en[0];
                edge_sel = sel[0];
                idle(10);
                for (int w = 1; w <= 6; w++) begin
                    pulse_run(en, sel, w);
                end
            end
        end
        // R6: strobe lasts one cycle even for a long high level
        @(negedge clk);
        flt_en = 1'b0;
        edge_sel = 1'b0;
        idle(10);
        begin
            int hi_cnt;
            hi_cnt = 0;
            evt_in = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (cap_vld) hi_cnt++;
            end
            check("R6 one-cycle strobe", hi_cnt, 1);
            evt_in = 1'b0;
            idle(10);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule